// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block turns a set of external interrupt lines into a masked pending vector. Each line has its own configuration. A polarity bit picks the active level or edge direction. A trigger bit picks level or edge detection. A dual-edge bit makes an edge source catch transitions in both directions. A level source follows its input through a synchronizer. An edge source records a detected edge in a sticky latch that stays set until software releases it. The pending state is ANDed with a per-source enable mask, and the result is passed on to whatever routes interrupts to processors.

Software reaches the block through a single-cycle word-addressed port. The write enable and address are sampled on the rising clock edge, and read data is combinational from the address. Configuration, mask and pending state are packed into 32-bit words, with source n in word n/32 at bit n%32. The mask changes only through separate set and clear ports. A one-word injection write can set or release the latch of any source by number.

Top module: `irq_src_cond`

## Requirements
- R1: After reset, the polarity, trigger, dual-edge and mask registers read as zero, and `irq_pend_o` is all zero.
- R2: A level source (trigger bit 0) shows as pending when its input equals its polarity bit (1 = active-high, 0 = active-low). The input passes through a two-flop synchronizer first.
- R3: An edge source (trigger bit 1, dual bit 0) latches pending on a rising input edge when polarity is 1, and on a falling edge when polarity is 0. The latch stays set while the input is idle.
- R4: An edge source with its dual bit set latches pending on both rising and falling input transitions.
- R5: Writing the set-mask port sets every mask bit where the data bit is 1. Bits where the data bit is 0 keep their value.
- R6: Writing the clear-mask port clears every mask bit where the data bit is 1. Bits where the data bit is 0 keep their value. In the mask view, a 1 means the source is enabled.
- R7: An injection write with bit 31 = 1 sets the edge latch of the source numbered in bits [7:0], and with bit 31 = 0 releases it. A source number at or above the source count has no effect.
- R8: When a detected edge and an injection release reach the same source in the same cycle, the latch ends up set.
- R9: `irq_pend_o[n]` is 1 exactly when source n is pending and its mask bit is 1.
- R10: Address bits [5:3] select the region: 0 polarity, 1 trigger, 2 dual-edge, 3 injection, 4 set-mask, 5 clear-mask, 6 mask view, 7 pending view. Bits [2:0] select the word. A word index at or above ceil(sources/32) reads as zero and ignores writes.
- R11: The polarity, trigger and dual-edge words read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw external interrupt lines |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Word address: region in [5:3], word in [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_pend_o | output | NUM_SRC | Masked pending vector |

## Verification
Some behaviours are checked by assertions on every cycle:
- the mask-port effects on the written word;
- an injection set reaching an edge latch;
- an edge latch never dropping without a release or a switch to level mode;
- a zero output right after reset.

Other behaviours only the bench's scenarios can show:
- the polarity, trigger and dual-edge combinations observed end to end through the synchronizer;
- the exact cycle in which an edge collides with a release;
- read-back of configuration words;
- the silence of out-of-range words and source numbers.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned ADDR_W   = 6;
   localparam int unsigned MAX_SRC  = 256;
   localparam int unsigned NUM_W    = 8;
   localparam int unsigned INJ_SET_BIT = 31;

   typedef enum logic [2:0] {
      RG_POL  = 3'd0,
      RG_TRIG = 3'd1,
      RG_DUAL = 3'd2,
      RG_INJ  = 3'd3,
      RG_MSET = 3'd4,
      RG_MCLR = 3'd5,
      RG_MASK = 3'd6,
      RG_PEND = 3'd7
   } region_e;

   typedef struct packed {
      logic pol;
      logic trig;
      logic dual;
   } src_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_cond_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [NUM_SRC-1:0]  pend_view,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_SRC-1:0]  pol_o,
   output logic [NUM_SRC-1:0]  trig_o,
   output logic [NUM_SRC-1:0]  dual_o,
   output logic [NUM_SRC-1:0]  mask_o,
   output logic [NUM_SRC-1:0]  inj_set_o,
   output logic [NUM_SRC-1:0]  inj_clr_o
);
   localparam int unsigned NWORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
   localparam int unsigned NPAD   = NWORDS * DATA_W;
   localparam logic [NPAD-1:0] VALID = {NPAD{1'b1}} >> (NPAD - NUM_SRC);

   logic [NPAD-1:0] pol_q, trig_q, dual_q, mask_q, pend_pad;
   region_e         rg;
   logic [2:0]      wsel;
   logic [7:0]      wbase;
   logic            word_ok;
   logic [DATA_W-1:0] wmask;
   logic [NUM_W-1:0]  inj_num;
   logic            inj_hit;

   assign rg       = region_e'(bus_addr[5:3]);
   assign wsel     = bus_addr[2:0];
   assign wbase    = {wsel, 5'd0};
   assign word_ok  = ({1'b0, wsel} < 4'(NWORDS));
   assign wmask    = word_ok ? VALID[wbase +: DATA_W] : '0;
   assign pend_pad = NPAD'(pend_view);
   assign inj_num  = bus_wdata[NUM_W-1:0];
   assign inj_hit  = bus_we && (rg == RG_INJ) && ({1'b0, inj_num} < 9'(NUM_SRC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         trig_q <= '0;
         dual_q <= '0;
         mask_q <= '0;
      end else if (bus_we && word_ok) begin
         case (rg)
            RG_POL:  pol_q[wbase +: DATA_W]  <= bus_wdata & wmask;
            RG_TRIG: trig_q[wbase +: DATA_W] <= bus_wdata & wmask;
            RG_DUAL: dual_q[wbase +: DATA_W] <= bus_wdata & wmask;
            RG_MSET: mask_q[wbase +: DATA_W] <= mask_q[wbase +: DATA_W] | (bus_wdata & wmask);
            RG_MCLR: mask_q[wbase +: DATA_W] <= mask_q[wbase +: DATA_W] & ~(bus_wdata & wmask);
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (word_ok) begin
         case (rg)
            RG_POL:  bus_rdata = pol_q[wbase +: DATA_W];
            RG_TRIG: bus_rdata = trig_q[wbase +: DATA_W];
            RG_DUAL: bus_rdata = dual_q[wbase +: DATA_W];
            RG_MASK: bus_rdata = mask_q[wbase +: DATA_W];
            RG_PEND: bus_rdata = pend_pad[wbase +: DATA_W];
            default: bus_rdata = '0;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_inj
      assign inj_set_o[i] = inj_hit && (inj_num == NUM_W'(i)) &&  bus_wdata[INJ_SET_BIT];
      assign inj_clr_o[i] = inj_hit && (inj_num == NUM_W'(i)) && !bus_wdata[INJ_SET_BIT];
   end

   assign pol_o  = pol_q[NUM_SRC-1:0];
   assign trig_o = trig_q[NUM_SRC-1:0];
   assign dual_o = dual_q[NUM_SRC-1:0];
   assign mask_o = mask_q[NUM_SRC-1:0];
endmodule

// File: rtl/irq_src_lane.sv
module irq_src_lane
   import irq_cond_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     irq_raw,
   input  src_cfg_t cfg,
   input  logic     inj_set,
   input  logic     inj_clr,
   output logic     pend_o,
   output logic     latch_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic prev_q, latch_q;
   logic cur, rise, fall, hit, level_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
         prev_q <= cur;
         if (!cfg.trig)
            latch_q <= 1'b0;
         else if (hit || inj_set)
            latch_q <= 1'b1;
         else if (inj_clr)
            latch_q <= 1'b0;
      end
   end

   assign cur       = sync_q[SYNC_STAGES-1];
   assign rise      = cur & ~prev_q;
   assign fall      = ~cur & prev_q;
   assign hit       = cfg.dual ? (rise | fall) : (cfg.pol ? rise : fall);
   assign level_act = ~(cur ^ cfg.pol);
   assign pend_o    = cfg.trig ? latch_q : level_act;
   assign latch_o   = latch_q;
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
   import irq_cond_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                bus_we,
   input  logic [5:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_SRC-1:0]  irq_pend_o
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_count
      $error("irq_src_cond: NUM_SRC out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_cond: SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, mask_q;
   logic [NUM_SRC-1:0] inj_set, inj_clr, pend_q, latch_q;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend_view (pend_q),
      .bus_rdata (bus_rdata),
      .pol_o     (pol_q),
      .trig_o    (trig_q),
      .dual_o    (dual_q),
      .mask_o    (mask_q),
      .inj_set_o (inj_set),
      .inj_clr_o (inj_clr)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      src_cfg_t cfg;
      assign cfg = '{pol: pol_q[i], trig: trig_q[i], dual: dual_q[i]};
      irq_src_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .irq_raw (irq_in[i]),
         .cfg     (cfg),
         .inj_set (inj_set[i]),
         .inj_clr (inj_clr[i]),
         .pend_o  (pend_q[i]),
         .latch_o (latch_q[i])
      );
   end

   assign irq_pend_o = pend_q & mask_q;
endmodule

// File: rtl/irq_src_cond_chk.sv
module irq_src_cond_chk #(
   parameter int unsigned NUM_SRC = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_we,
   input logic [5:0]         bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] irq_pend_o,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] trig_q,
   input logic [NUM_SRC-1:0] latch_q
);
   localparam int unsigned NWORDS = (NUM_SRC + 31) / 32;
   localparam int unsigned NPAD   = NWORDS * 32;
   localparam logic [NPAD-1:0] VALID = {NPAD{1'b1}} >> (NPAD - NUM_SRC);

   logic [NPAD-1:0] mpad;
   assign mpad = NPAD'(mask_q);

   function automatic logic bit_at(logic [NUM_SRC-1:0] v, logic [7:0] idx);
      return ({1'b0, idx} < 9'(NUM_SRC)) ? v[idx] : 1'b0;
   endfunction

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      // R5
      mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == {3'd4, 3'(w)}) |=>
         ((mpad[w*32 +: 32] & $past(bus_wdata) & VALID[w*32 +: 32]) ==
          ($past(bus_wdata) & VALID[w*32 +: 32])));
      // R6
      mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == {3'd5, 3'(w)}) |=>
         ((mpad[w*32 +: 32] & $past(bus_wdata)) == '0));
   end

   // R7
   inj_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[5:3] == 3'd3 && bus_wdata[31] && bit_at(trig_q, bus_wdata[7:0]))
      |=> bit_at(latch_q, $past(bus_wdata[7:0])));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      // R3
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_q[i] && trig_q[i] &&
          !(bus_we && bus_addr[5:3] == 3'd3 && !bus_wdata[31] && bus_wdata[7:0] == 8'(i)))
         |=> latch_q[i]);
   end

   // R1
   out_after_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_pend_o == '0));
endmodule

bind irq_src_cond irq_src_cond_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .irq_pend_o (irq_pend_o),
   .mask_q     (mask_q),
   .trig_q     (trig_q),
   .latch_q    (latch_q)
);

// File: tb/tb_irq_src_cond.sv
module tb_irq_src_cond;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 64;
   localparam int S = 5;
   localparam int NVEC = 11;
   // {pol, trig, dual, input_before, input_after, expected_pending}
   localparam logic [5:0] VEC [0:NVEC-1] = '{
      6'b100_01_1, 6'b100_10_0, 6'b000_10_1, 6'b000_01_0,
      6'b110_01_1, 6'b110_10_0, 6'b010_10_1, 6'b010_01_0,
      6'b111_01_1, 6'b111_10_1, 6'b110_11_0
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NSRC-1:0] irq_in = '0;
   logic bus_we = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, rd, rd2;
   logic [31:0] bus_rdata;
   logic [NSRC-1:0] irq_pend_o;
   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_src_cond #(.NUM_SRC(NSRC)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pend_o(irq_pend_o));

   function automatic logic [5:0] adr(int rg, int w);
      return {3'(rg), 3'(w)};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rdw(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      idle(3);
      #2 rst_n = 1'b1;
      // R1 reset state
      rdw(adr(0,0), rd); chk("R1 pol", rd, 0);
      rdw(adr(1,1), rd); chk("R1 trig", rd, 0);
      rdw(adr(2,0), rd); chk("R1 dual", rd, 0);
      rdw(adr(6,1), rd); chk("R1 mask", rd, 0);
      chk("R1 out", 32'(irq_pend_o), 0);
      // R2 default active-low level with all inputs low -> all pending
      rdw(adr(7,0), rd); chk("R2 default pending", rd, 32'hFFFF_FFFF);

      // R11 read-back, R10 out-of-range word
      wr(adr(2,1), 32'hA5A5_5A5A);
      rdw(adr(2,1), rd); chk("R11 dual readback", rd, 32'hA5A5_5A5A);
      wr(adr(2,1), 32'h0);
      wr(adr(0,3), 32'hFFFF_FFFF);
      rdw(adr(0,3), rd); chk("R10 absent word reads 0", rd, 0);
      rdw(adr(0,0), rd); chk("R10 absent word write ignored", rd, 0);

      // R5/R6 mask ports
      wr(adr(4,1), 32'hF0F0_0000);
      wr(adr(5,1), 32'h3000_0000);
      rdw(adr(6,1), rd); chk("R5 R6 mask view", rd, 32'hC0F0_0000);
      wr(adr(4,1), 32'h0000_0000);
      rdw(adr(6,1), rd); chk("R5 zero set bits keep", rd, 32'hC0F0_0000);

      // Table: source S in word 0, mask enabled
      wr(adr(4,0), 32'(1) << S);
      for (int k = 0; k < NVEC; k++) begin
         logic [5:0] v;
         v = VEC[k];
         wr(adr(0,0), 32'(v[5]) << S);
         wr(adr(1,0), 32'(v[4]) << S);
         wr(adr(2,0), 32'(v[3]) << S);
         @(negedge clk); irq_in[S] = v[2];
         idle(5);
         wr(adr(3,0), 32'(S));
         idle(2);
         irq_in[S] = v[1];
         idle(5);
         rdw(adr(7,0), rd);
         chk($sformatf("R2 R3 R4 vec%0d pend view", k), 32'(rd[S]), 32'(v[0]));
         chk($sformatf("R9 vec%0d masked out", k), 32'(irq_pend_o[S]), 32'(v[0]));
      end
      // R9 masked off -> output low while pending high (last vec level pol0 in=... set level pend)
      wr(adr(0,0), 32'h0); wr(adr(1,0), 32'h0); wr(adr(2,0), 32'h0);
      @(negedge clk); irq_in[S] = 1'b0;
      idle(4);
      chk("R9 enabled pending", 32'(irq_pend_o[S]), 1);
      wr(adr(5,0), 32'(1) << S);
      chk("R9 masked off", 32'(irq_pend_o[S]), 0);

      // R7 injection on source 40 (word1 bit8), edge, pol 1
      wr(adr(0,1), 32'h0000_0300);
      wr(adr(1,1), 32'h0000_0300);
      wr(adr(4,1), 32'h0000_0300);
      idle(4);
      rdw(adr(7,1), rd); chk("R3 edge idle no pend", rd & 32'h300, 0);
      wr(adr(3,0), 32'h8000_0028);
      rdw(adr(7,1), rd); chk("R7 inject set", rd & 32'h300, 32'h100);
      chk("R9 inject out", 32'(irq_pend_o[40]), 1);
      wr(adr(3,0), 32'h0000_0028);
      rdw(adr(7,1), rd); chk("R7 inject clear", rd & 32'h300, 0);
      // R7 out-of-range number ignored
      rdw(adr(7,0), rd2);
      wr(adr(3,0), 32'h8000_00C8);
      rdw(adr(7,1), rd); chk("R7 out-of-range word1", rd, 32'hFFFF_FCFF);
      rdw(adr(7,0), rd); chk("R7 out-of-range word0", rd, rd2);

      // R8 edge on source 41 collides with release
      @(negedge clk); irq_in[41] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = adr(3,0); bus_wdata = 32'h0000_0029; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      rdw(adr(7,1), rd); chk("R8 set wins", 32'(rd[9]), 1);
      wr(adr(3,0), 32'h0000_0029);
      rdw(adr(7,1), rd); chk("R8 later release", 32'(rd[9]), 0);
      // R3 falling edge on pol1 source does not latch
      @(negedge clk); irq_in[41] = 1'b0;
      idle(5);
      rdw(adr(7,1), rd); chk("R3 opposite edge ignored", 32'(rd[9]), 0);

      finish_run();
   end
endmodule